// File: doc/BRIEF.md
# Vertical-Crosswise 4x4 Unsigned Multiplier

This block multiplies two 4-bit unsigned operands and returns the full 8-bit product in the same cycle. It is purely combinational: no clock, no register and no handshake. A parent either registers the result or uses it directly. Each of the sixteen bit pairs of the operands gets one AND gate. The partial products are summed column by column in the vertical-and-crosswise manner. Every column is reduced as carry-save, with half adders, full adders and one five-input ones-counter cell. The counter cell sits in column 3, the column of weight 8, which is the densest one.

A build-time parameter selects a second structure for side-by-side comparison. In that structure each operand is split into a high and a low 2-bit half. Four 2x2 sub-multipliers form the cross products, and three 4-bit ripple-carry adders merge them. Both structures give the same product for every operand pair. The operands feed combinational logic only, so the stream handshake used elsewhere in the project does not apply here: the output follows the inputs after propagation delay, and no back-pressure exists.

Top module: `vcm_mul4`

## Requirements
- R1: With `STRUCT`=0 (counter-based column reduction), `q_o` equals the unsigned product `a_i`*`b_i` for all 256 operand pairs.
- R2: Bit 0 of `q_o` is the AND of bit 0 of `a_i` and bit 0 of `b_i`.
- R3: The ones-counter cell outputs a 3-bit binary count `{c1,c0,s}` (c1 is bit 2, s is bit 0) equal to the number of its five 1-bit inputs that are 1. Four ones give 3'b100 and five ones give 3'b101.
- R4: With `STRUCT`=1 (four 2x2 sub-products merged by ripple-carry adders), `q_o` matches the `STRUCT`=0 result for every operand pair. The two carries out of the lower merge adders are never both 1.
- R5: The 2x2 sub-multiplier returns the 4-bit product of its two 2-bit operands. Bit 0 is the AND of the low bits, and bit 1 is the XOR of the two cross terms.
- R6: Fixed sample products: 10*11=110 (8'b01101110), 15*15=225 (8'b11100001), 13*7=91, 6*13=78.
- R7: A zero operand on either side gives a product of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | Multiplicand, unsigned, bit 0 least significant |
| b_i | input | 4 | Multiplier, unsigned, bit 0 least significant |
| q_o | output | 8 | Unsigned product, bit 0 least significant |

## Verification
Immediate assertions re-evaluate whenever the logic settles. They check four things: the top-level product against the arithmetic product, the least significant bit against the AND of the operand LSBs, each counter cell and 2x2 sub-multiplier against its own arithmetic meaning, and that the two lower merge carries are mutually exclusive. Some behaviour only the bench scenarios can show. This covers agreement between the two build variants, the fixed sample products, and full coverage of every operand pair and every counter input pattern. Each of these needs an instance of each variant and a sweep over stimulus.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
  localparam int OP_W   = 4;
  localparam int PROD_W = 2 * OP_W;
  localparam int HALF_W = OP_W / 2;
  localparam int STRUCT_COUNTER = 0;
  localparam int STRUCT_SPLIT   = 1;
endpackage

// File: rtl/vcm_half_add.sv
module vcm_half_add (
  input  logic a,
  input  logic b,
  output logic s,
  output logic co
);
  assign s  = a ^ b;
  assign co = a & b;
endmodule

// File: rtl/vcm_full_add.sv
module vcm_full_add (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  logic p;
  assign p  = a ^ b;
  assign s  = p ^ ci;
  assign co = (a & b) | (p & ci);
endmodule

// File: rtl/vcm_ones5.sv
module vcm_ones5 (
  input  logic x,
  input  logic y,
  input  logic z,
  input  logic w,
  input  logic ca,
  output logic s,
  output logic c0,
  output logic c1
);
  logic s_a, k_a, k_b;

  vcm_full_add u_fa_a (.a(x),   .b(y), .ci(z),  .s(s_a), .co(k_a));
  vcm_full_add u_fa_b (.a(s_a), .b(w), .ci(ca), .s(s),   .co(k_b));
  vcm_half_add u_ha   (.a(k_a), .b(k_b), .s(c0), .co(c1));

  always_comb begin
    AST_CNT_EXACT: assert ({29'd0, c1, c0, s} == $countones({x, y, z, w, ca})); // R3
    AST_CNT_RANGE: assert ({c1, c0, s} <= 3'd5); // R3
  end
endmodule

// File: rtl/vcm_mul2.sv
module vcm_mul2 (
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [3:0] p
);
  logic k1;

  assign p[0] = a[0] & b[0];
  vcm_half_add u_ha_x (.a(a[1] & b[0]), .b(a[0] & b[1]), .s(p[1]), .co(k1));
  vcm_half_add u_ha_h (.a(a[1] & b[1]), .b(k1),          .s(p[2]), .co(p[3]));

  always_comb begin
    AST_SUB_PRODUCT: assert (p == {2'b00, a} * {2'b00, b}); // R5
  end
endmodule

// File: rtl/vcm_rca.sv
module vcm_rca #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] c;
  assign c[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    vcm_full_add u_fa (.a(a[i]), .b(b[i]), .ci(c[i]), .s(s[i]), .co(c[i+1]));
  end

  assign co = c[W];
endmodule

// File: rtl/vcm_mul4.sv
module vcm_mul4
  import vcm_pkg::*;
#(
  parameter int STRUCT = STRUCT_COUNTER
) (
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  output logic [7:0] q_o
);
  if (STRUCT == STRUCT_COUNTER) begin : g_counter
    logic [OP_W-1:0][OP_W-1:0] pp;  // pp[i][j] = a[i] & b[j], column i+j
    logic k1, k2a, k2b, h3c, cs, cc0, cc1;
    logic s4, k4a, k4b, s5, k5a, k5b;

    for (genvar i = 0; i < OP_W; i++) begin : g_row
      for (genvar j = 0; j < OP_W; j++) begin : g_col
        assign pp[i][j] = a_i[i] & b_i[j];
      end
    end

    logic s2;
    // column 0
    assign q_o[0] = pp[0][0];
    // column 1
    vcm_half_add u_ha_c1 (.a(pp[1][0]), .b(pp[0][1]), .s(q_o[1]), .co(k1));
    // column 2
    vcm_full_add u_fa_c2 (.a(pp[2][0]), .b(pp[1][1]), .ci(pp[0][2]), .s(s2), .co(k2a));
    vcm_half_add u_ha_c2 (.a(s2), .b(k1), .s(q_o[2]), .co(k2b));
    // column 3: densest column, five-input counter plus one half adder
    vcm_ones5 u_cnt (.x(pp[3][0]), .y(pp[2][1]), .z(pp[1][2]), .w(pp[0][3]),
                     .ca(k2a), .s(cs), .c0(cc0), .c1(cc1));
    vcm_half_add u_ha_c3 (.a(cs), .b(k2b), .s(q_o[3]), .co(h3c));
    // column 4
    vcm_full_add u_fa_c4a (.a(pp[3][1]), .b(pp[2][2]), .ci(pp[1][3]), .s(s4), .co(k4a));
    vcm_full_add u_fa_c4b (.a(s4), .b(cc0), .ci(h3c), .s(q_o[4]), .co(k4b));
    // column 5 (counter's weight-4 output lands here)
    vcm_full_add u_fa_c5a (.a(pp[3][2]), .b(pp[2][3]), .ci(cc1), .s(s5), .co(k5a));
    vcm_full_add u_fa_c5b (.a(s5), .b(k4a), .ci(k4b), .s(q_o[5]), .co(k5b));
    // column 6 and top bit
    vcm_full_add u_fa_c6 (.a(pp[3][3]), .b(k5a), .ci(k5b), .s(q_o[6]), .co(q_o[7]));
  end else begin : g_split
    logic [3:0] p_ll, p_hl, p_lh, p_hh;
    logic [3:0] s_x, s_m, s_h;
    logic       k_x, k_m, k_h;

    vcm_mul2 u_m_ll (.a(a_i[HALF_W-1:0]),    .b(b_i[HALF_W-1:0]),    .p(p_ll));
    vcm_mul2 u_m_hl (.a(a_i[OP_W-1:HALF_W]), .b(b_i[HALF_W-1:0]),    .p(p_hl));
    vcm_mul2 u_m_lh (.a(a_i[HALF_W-1:0]),    .b(b_i[OP_W-1:HALF_W]), .p(p_lh));
    vcm_mul2 u_m_hh (.a(a_i[OP_W-1:HALF_W]), .b(b_i[OP_W-1:HALF_W]), .p(p_hh));

    vcm_rca #(.W(OP_W)) u_rca_x (.a(p_hl), .b(p_lh), .s(s_x), .co(k_x));
    vcm_rca #(.W(OP_W)) u_rca_m (.a(s_x), .b({2'b00, p_ll[3:2]}), .s(s_m), .co(k_m));
    vcm_rca #(.W(OP_W)) u_rca_h (.a(p_hh), .b({1'b0, k_x | k_m, s_m[3:2]}),
                                 .s(s_h), .co(k_h));

    assign q_o = {s_h, s_m[1:0], p_ll[1:0]};

    always_comb begin
      AST_MERGE_EXCL: assert (!(k_x && k_m)); // R4
      AST_TOP_NOCARRY: assert (!k_h); // R4
    end
  end

  always_comb begin
    AST_PRODUCT: assert (q_o == {4'b0000, a_i} * {4'b0000, b_i}); // R1
    AST_LSB: assert (q_o[0] == (a_i[0] & b_i[0])); // R2
    AST_ZERO: assert (!((a_i == 4'd0) || (b_i == 4'd0)) || (q_o == 8'd0)); // R7
  end
endmodule

// File: tb/tb_vcm_mul4.sv
module tb_vcm_mul4;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0] a, b;
  logic [7:0] q0, q1;
  logic [1:0] ma, mb;
  logic [3:0] mp;
  logic [4:0] cin;
  logic cs, cc0, cc1;

  int n_run = 0;
  int n_fail = 0;

  vcm_mul4 #(.STRUCT(0)) dut      (.a_i(a), .b_i(b), .q_o(q0));
  vcm_mul4 #(.STRUCT(1)) dut_split (.a_i(a), .b_i(b), .q_o(q1));
  vcm_mul2  u_m2  (.a(ma), .b(mb), .p(mp));
  vcm_ones5 u_cnt (.x(cin[4]), .y(cin[3]), .z(cin[2]), .w(cin[1]), .ca(cin[0]),
                   .s(cs), .c0(cc0), .c1(cc1));

  // {a, b, expected product}
  localparam logic [15:0] VEC [6] = '{
    {4'd10, 4'd11, 8'b01101110},
    {4'd15, 4'd15, 8'b11100001},
    {4'd13, 4'd7,  8'd91},
    {4'd6,  4'd13, 8'd78},
    {4'd1,  4'd2,  8'd2},
    {4'd4,  4'd5,  8'd20}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] va, input logic [3:0] vb);
    @(posedge clk);
    a = va;
    b = vb;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    a = '0; b = '0; ma = '0; mb = '0; cin = '0;
    #1;
    chk("R7 initial zero operands", int'(q0), 0);

    // R6: sample table
    for (int k = 0; k < 6; k++) begin
      apply(VEC[k][15:12], VEC[k][11:8]);
      chk("R6 sample counter", int'(q0), int'(VEC[k][7:0]));
      chk("R6 sample split", int'(q1), int'(VEC[k][7:0]));
    end

    // R1, R2, R4, R7: exhaustive operand sweep
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        apply(4'(i), 4'(j));
        if (i == 0 || j == 0) chk("R7 zero operand", int'(q0), 0);
        else chk("R1 product", int'(q0), i * j);
        chk("R2 lsb", int'(q0[0]), (i & j) & 1);
        chk("R4 split matches counter", int'(q1), int'(q0));
        chk("R4 split product", int'(q1), i * j);
      end
    end

    // R5: 2x2 sub-multiplier exhaustive
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        @(posedge clk);
        ma = 2'(i);
        mb = 2'(j);
        #1;
        chk("R5 sub product", int'(mp), i * j);
        chk("R5 cross bit", int'(mp[1]), ((i >> 1) & j & 1) ^ (i & (j >> 1) & 1));
      end
    end

    // R3: ones-counter cell exhaustive
    for (int v = 0; v < 32; v++) begin
      @(posedge clk);
      cin = 5'(v);
      #1;
      chk("R3 ones count", int'({cc1, cc0, cs}), $countones(5'(v)));
    end
    @(posedge clk); cin = 5'b11111; #1;
    chk("R3 all five set", int'({cc1, cc0, cs}), 5);
    @(posedge clk); cin = 5'b11011; #1;
    chk("R3 four set", int'({cc1, cc0, cs}), 4);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule